// File: doc/BRIEF.md
# Fail-safe clock monitor and switcher

This block decides which of four clock groups drives the system: an external primary oscillator, a secondary oscillator, an internal fast RC oscillator and an internal slow RC oscillator. It runs on an always-on reference clock. Each group reports two things, both already synchronised to the reference clock: a toggle line that changes level with its oscillator, and a ready flag. Analog glitch-free muxing is not modelled here; the block only produces a one-hot select vector for that mux.

Software requests a switch by writing a new-group code and raising the switch-enable bit. The switch completes once the target group reports ready. If software writes the enable bit as zero before then, the switch is abandoned. When monitoring is on, the block watches the current group's toggle line. If no toggle arrives within a window of reference cycles, or the start-up timer expires while the current group is still not ready, the hardware takes over. It forces the fast RC group, sets a sticky fail flag, drops any pending switch and emits a one-cycle trap pulse.

A two-bit mode input governs the block. Any value with the upper bit set turns off both switching and monitoring; in that case the configuration group code drives the selection directly. The interface consists of control and status pins only, and there is no streaming data path.

Top module: `clk_failsafe_switch`

## Requirements
- R1: While `rst_n` is low, `cur_src` and `new_src` are loaded from `cfg_osc`, and `clk_fail`, `fail_trap` and `sw_pend` are 0. Group codes are 0 = primary, 1 = secondary, 2 = fast RC, 3 = slow RC.
- R2: `clk_sel` is one-hot, with bit number `cur_src` set.
- R3: With `cfg_mode[1]` = 1, `cur_src` takes the value `cfg_osc` had one cycle earlier. Control writes cannot start a switch, so `sw_pend` stays 0. A stalled toggle line produces no failure.
- R4: With switching enabled, a write with `ctl_wr`=1 and `ctl_swen`=1 while `sw_pend`=0 loads `new_src` from `ctl_nsrc` and sets `sw_pend` on the next cycle. `cur_src` does not change while the target's `src_ok` bit is 0.
- R5: While `sw_pend`=1 and `src_ok[new_src]`=1, the next cycle gives `cur_src` = `new_src` and `sw_pend` = 0.
- R6: A write with `ctl_swen`=0 clears `sw_pend` on the next cycle and leaves `cur_src` unchanged, even if the target later becomes ready.
- R7: With `cfg_mode` = 00, if the current group's toggle line holds its level for WIN consecutive reference cycles, the next cycle gives `cur_src` = 2, `clk_fail` = 1 and `sw_pend` = 0.
- R8: `fail_trap` is high for exactly one cycle per detected failure, in the same cycle that the failure's effects first appear.
- R9: With `cfg_mode` = 00, a rising edge on `start_tmr_done` while `src_ok[cur_src]`=0 is a failure with the effects of R7 and R8.
- R10: `clk_fail` stays at 1 until a write with `ctl_clr_fail`=1. If a failure falls in the same cycle as that write, the flag stays set.
- R11: If a failure and a switch completion fall in the same cycle, the failure wins: `cur_src` = 2, `sw_pend` = 0.
- R12: With `cfg_mode` = 01, switching works as in R4 and R5, but a stalled toggle line causes no failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Synchronous power-on/brown-out reset, active low |
| cfg_mode | input | 2 | 1x = all off, 01 = switching only, 00 = switching and monitor |
| cfg_osc | input | 2 | Configured group code |
| src_tgl | input | 4 | Per-group oscillator toggle indication |
| src_ok | input | 4 | Per-group oscillator ready flag |
| start_tmr_done | input | 1 | Start-up timer expired (level) |
| ctl_wr | input | 1 | Control write strobe |
| ctl_nsrc | input | 2 | Requested group code |
| ctl_swen | input | 1 | Switch-enable value written |
| ctl_clr_fail | input | 1 | Clear the fail flag with this write |
| cur_src | output | 2 | Group currently in effect |
| new_src | output | 2 | Requested group |
| sw_pend | output | 1 | Switch-enable bit (switch pending) |
| clk_sel | output | 4 | One-hot select for the clock mux |
| clk_fail | output | 1 | Sticky clock-fail flag |
| fail_trap | output | 1 | One-cycle trap request |

## Verification
Two events can land in the same reference cycle: starvation detection on the running group, and completion of a pending switch to another group. The bench first leaves a switch pending toward a group that is not ready. It then stops the current group's toggle line and counts exactly WIN cycles, so that the target's ready flag rises in the cycle in which the window expires. The expected result is the fast RC code with the switch dropped, the fail flag set and a single trap taken from the scoreboard. The same counting places a fail-flag clear write on the failure cycle.

// File: rtl/fscm_pkg.sv
package fscm_pkg;
  localparam int GRP_W = 2;

  typedef enum logic [GRP_W-1:0] {
    GRP_PRI     = 2'd0,
    GRP_SEC     = 2'd1,
    GRP_FAST_RC = 2'd2,
    GRP_SLOW_RC = 2'd3
  } grp_e;
endpackage

// File: rtl/fscm_edge_watch.sv
module fscm_edge_watch
  import fscm_pkg::*;
#(
  parameter int N_GRP = 4,
  parameter int WIN   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mon_en,
  input  logic [N_GRP-1:0] src_tgl,
  input  logic [N_GRP-1:0] src_ok,
  input  grp_e             cur,
  input  logic             tmr_done,
  output logic             fail_req
);
  localparam int CW = $clog2(WIN + 1);

  logic [N_GRP-1:0] edge_v;
  logic [CW-1:0]    cnt_q;
  grp_e             cur_last_q;
  logic             tmr_q;
  logic             starve, miss, quiet_rst;

  for (genvar g = 0; g < N_GRP; g++) begin : g_src
    logic p_q;
    always_ff @(posedge clk) begin
      if (!rst_n) p_q <= 1'b0;
      else        p_q <= src_tgl[g];
    end
    assign edge_v[g] = src_tgl[g] ^ p_q;
  end

  always_comb begin
    starve    = mon_en && !edge_v[cur] && (cur == cur_last_q) && (cnt_q == CW'(WIN - 1));
    miss      = mon_en && tmr_done && !tmr_q && !src_ok[cur];
    fail_req  = starve || miss;
    quiet_rst = !mon_en || edge_v[cur] || (cur != cur_last_q) || fail_req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      cur_last_q <= GRP_PRI;
      tmr_q      <= 1'b0;
    end else begin
      cur_last_q <= cur;
      tmr_q      <= tmr_done;
      if (quiet_rst) cnt_q <= '0;
      else           cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(WIN)); // R7
  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en |=> cnt_q == '0); // R12
endmodule

// File: rtl/fscm_switch_ctrl.sv
module fscm_switch_ctrl
  import fscm_pkg::*;
#(
  parameter int N_GRP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_mode,
  input  logic [GRP_W-1:0] cfg_osc,
  input  logic [N_GRP-1:0] src_ok,
  input  logic             ctl_wr,
  input  logic [GRP_W-1:0] ctl_nsrc,
  input  logic             ctl_swen,
  input  logic             ctl_clr_fail,
  input  logic             fail_req,
  output grp_e             cur_q,
  output grp_e             nsrc_q,
  output logic             swen_q,
  output logic             cf_q,
  output logic             trap_q
);
  grp_e cur_n, nsrc_n;
  logic swen_n, cf_n, trap_n, sw_off;

  assign sw_off = cfg_mode[1];

  always_comb begin
    cur_n  = cur_q;
    nsrc_n = nsrc_q;
    swen_n = swen_q;
    cf_n   = cf_q;
    trap_n = 1'b0;
    if (sw_off) begin
      cur_n  = grp_e'(cfg_osc);
      swen_n = 1'b0;
    end else begin
      if (swen_q && src_ok[nsrc_q]) begin
        cur_n  = nsrc_q;
        swen_n = 1'b0;
      end
      if (ctl_wr) begin
        nsrc_n = grp_e'(ctl_nsrc);
        if (!ctl_swen)    swen_n = 1'b0;
        else if (!swen_q) swen_n = 1'b1;
      end
    end
    if (ctl_wr && ctl_clr_fail) cf_n = 1'b0;
    if (fail_req && !sw_off) begin
      cur_n  = GRP_FAST_RC;
      swen_n = 1'b0;
      cf_n   = 1'b1;
      trap_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= grp_e'(cfg_osc);
      nsrc_q <= grp_e'(cfg_osc);
      swen_q <= 1'b0;
      cf_q   <= 1'b0;
      trap_q <= 1'b0;
    end else begin
      cur_q  <= cur_n;
      nsrc_q <= nsrc_n;
      swen_q <= swen_n;
      cf_q   <= cf_n;
      trap_q <= trap_n;
    end
  end

  AST_DIS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    sw_off |=> (cur_q == grp_e'($past(cfg_osc))) && !swen_q); // R3
  AST_CUR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_off && !swen_q && !fail_req) |=> $stable(cur_q)); // R4
  AST_SW_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_off && swen_q && src_ok[nsrc_q] && !fail_req && !ctl_wr)
      |=> (cur_q == $past(nsrc_q)) && !swen_q); // R5
  AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_off && ctl_wr && !ctl_swen) |=> !swen_q); // R6
  AST_FAIL_FRC: assert property (@(posedge clk) disable iff (!rst_n)
    fail_req |=> (cur_q == GRP_FAST_RC) && cf_q && !swen_q); // R7
  AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_q |-> $past(fail_req)); // R8
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cf_q && !(ctl_wr && ctl_clr_fail)) |=> cf_q); // R10
endmodule

// File: rtl/fscm_sel_decode.sv
module fscm_sel_decode
  import fscm_pkg::*;
#(
  parameter int N_GRP = 4
) (
  input  grp_e             cur,
  output logic [N_GRP-1:0] sel
);
  for (genvar g = 0; g < N_GRP; g++) begin : g_sel
    assign sel[g] = (cur == grp_e'(g));
  end
endmodule

// File: rtl/clk_failsafe_switch.sv
module clk_failsafe_switch
  import fscm_pkg::*;
#(
  parameter int N_GRP = 4,
  parameter int WIN   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_mode,
  input  logic [GRP_W-1:0] cfg_osc,
  input  logic [N_GRP-1:0] src_tgl,
  input  logic [N_GRP-1:0] src_ok,
  input  logic             start_tmr_done,
  input  logic             ctl_wr,
  input  logic [GRP_W-1:0] ctl_nsrc,
  input  logic             ctl_swen,
  input  logic             ctl_clr_fail,
  output logic [GRP_W-1:0] cur_src,
  output logic [GRP_W-1:0] new_src,
  output logic             sw_pend,
  output logic [N_GRP-1:0] clk_sel,
  output logic             clk_fail,
  output logic             fail_trap
);
  grp_e cur, nsrc;
  logic fail_req, mon_en;

  assign mon_en = (cfg_mode == 2'b00);

  fscm_edge_watch #(.N_GRP(N_GRP), .WIN(WIN)) u_watch (
    .clk      (clk),
    .rst_n    (rst_n),
    .mon_en   (mon_en),
    .src_tgl  (src_tgl),
    .src_ok   (src_ok),
    .cur      (cur),
    .tmr_done (start_tmr_done),
    .fail_req (fail_req)
  );

  fscm_switch_ctrl #(.N_GRP(N_GRP)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_mode     (cfg_mode),
    .cfg_osc      (cfg_osc),
    .src_ok       (src_ok),
    .ctl_wr       (ctl_wr),
    .ctl_nsrc     (ctl_nsrc),
    .ctl_swen     (ctl_swen),
    .ctl_clr_fail (ctl_clr_fail),
    .fail_req     (fail_req),
    .cur_q        (cur),
    .nsrc_q       (nsrc),
    .swen_q       (sw_pend),
    .cf_q         (clk_fail),
    .trap_q       (fail_trap)
  );

  fscm_sel_decode #(.N_GRP(N_GRP)) u_sel (
    .cur (cur),
    .sel (clk_sel)
  );

  assign cur_src = cur;
  assign new_src = nsrc;

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(clk_sel) && clk_sel[cur_src]); // R2
  AST_TRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    fail_trap |-> clk_fail && (cur_src == 2'd2)); // R8
endmodule

// File: tb/clk_failsafe_switch_test.sv
module clk_failsafe_switch_test;
  localparam int WIN = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic [1:0] cfg_osc = 2'd1;
  logic [3:0] src_tgl = 4'h0;
  logic [3:0] src_ok = 4'hF;
  logic       start_tmr_done = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [1:0] ctl_nsrc = 2'd0;
  logic       ctl_swen = 1'b0;
  logic       ctl_clr_fail = 1'b0;
  logic [1:0] cur_src, new_src;
  logic       sw_pend, clk_fail, fail_trap;
  logic [3:0] clk_sel;
  logic [3:0] run_mask = 4'hF;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [1:0] exp_q[$];

  clk_failsafe_switch #(.N_GRP(4), .WIN(WIN)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_osc(cfg_osc),
    .src_tgl(src_tgl), .src_ok(src_ok), .start_tmr_done(start_tmr_done),
    .ctl_wr(ctl_wr), .ctl_nsrc(ctl_nsrc), .ctl_swen(ctl_swen),
    .ctl_clr_fail(ctl_clr_fail), .cur_src(cur_src), .new_src(new_src),
    .sw_pend(sw_pend), .clk_sel(clk_sel), .clk_fail(clk_fail),
    .fail_trap(fail_trap)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    #2;
    src_tgl = src_tgl ^ run_mask;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: each trap pops one expected entry
  always @(negedge clk) begin
    if (rst_n && fail_trap) begin
      if (exp_q.size() == 0) begin
        check("R8 unexpected trap", 8'd1, 8'd0);
      end else begin
        logic [1:0] e;
        e = exp_q.pop_front();
        check("R8 trap group", {6'd0, cur_src}, {6'd0, e});
      end
    end
  end

  task automatic wr(input logic [1:0] ns, input logic sw, input logic clr);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_nsrc = ns; ctl_swen = sw; ctl_clr_fail = clr;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_swen = 1'b0; ctl_clr_fail = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      summary();
    end
  end

  initial begin
    settle(3);
    // R1 reset load, R2 select
    check("R1 cur", {6'd0, cur_src}, 8'd1);
    check("R1 new", {6'd0, new_src}, 8'd1);
    check("R1 flags", {5'd0, clk_fail, fail_trap, sw_pend}, 8'd0);
    check("R2 sel", {4'd0, clk_sel}, 8'h02);
    rst_n = 1'b1;
    settle(3);

    // R4 pending switch to primary, not ready
    src_ok[0] = 1'b0;
    wr(2'd0, 1'b1, 1'b0);
    check("R4 pend", {7'd0, sw_pend}, 8'd1);
    check("R4 new", {6'd0, new_src}, 8'd0);
    settle(3);
    check("R4 hold", {6'd0, cur_src}, 8'd1);
    src_ok[0] = 1'b1;
    settle(1);
    check("R5 cur", {6'd0, cur_src}, 8'd0);
    check("R5 pend", {7'd0, sw_pend}, 8'd0);
    check("R2 sel", {4'd0, clk_sel}, 8'h01);

    // R6 abort
    src_ok[3] = 1'b0;
    wr(2'd3, 1'b1, 1'b0);
    check("R6 pend set", {7'd0, sw_pend}, 8'd1);
    wr(2'd3, 1'b0, 1'b0);
    check("R6 pend clr", {7'd0, sw_pend}, 8'd0);
    src_ok[3] = 1'b1;
    settle(2);
    check("R6 cur", {6'd0, cur_src}, 8'd0);

    // R7/R8 starvation of primary
    exp_q.push_back(2'd2);
    @(negedge clk); run_mask[0] = 1'b0;
    settle(WIN);
    check("R7 before window", {6'd0, cur_src}, 8'd0);
    settle(1);
    check("R8 trap", {7'd0, fail_trap}, 8'd1);
    settle(1);
    check("R7 cur", {6'd0, cur_src}, 8'd2);
    check("R7 flag", {7'd0, clk_fail}, 8'd1);
    check("R8 single", {7'd0, fail_trap}, 8'd0);
    run_mask[0] = 1'b1;
    settle(5);
    check("R10 sticky", {7'd0, clk_fail}, 8'd1);
    wr(2'd2, 1'b0, 1'b1);
    check("R10 clear", {7'd0, clk_fail}, 8'd0);

    // R11 failure vs completion in one cycle
    wr(2'd0, 1'b1, 1'b0);
    settle(1);
    check("R5 to primary", {6'd0, cur_src}, 8'd0);
    src_ok[1] = 1'b0;
    wr(2'd1, 1'b1, 1'b0);
    exp_q.push_back(2'd2);
    @(negedge clk); run_mask[0] = 1'b0;
    settle(WIN);
    check("R11 pre pend", {7'd0, sw_pend}, 8'd1);
    src_ok[1] = 1'b1;
    settle(1);
    check("R11 cur", {6'd0, cur_src}, 8'd2);
    check("R11 pend", {7'd0, sw_pend}, 8'd0);
    check("R11 flag", {7'd0, clk_fail}, 8'd1);
    run_mask[0] = 1'b1;

    // R10 clear write loses to failure in the same cycle
    wr(2'd0, 1'b0, 1'b1);
    check("R10 clear2", {7'd0, clk_fail}, 8'd0);
    wr(2'd0, 1'b1, 1'b0);
    settle(1);
    exp_q.push_back(2'd2);
    @(negedge clk); run_mask[0] = 1'b0;
    settle(WIN);
    ctl_wr = 1'b1; ctl_nsrc = 2'd0; ctl_swen = 1'b0; ctl_clr_fail = 1'b1;
    settle(1);
    ctl_wr = 1'b0; ctl_clr_fail = 1'b0;
    check("R10 set wins", {7'd0, clk_fail}, 8'd1);
    check("R10 cur", {6'd0, cur_src}, 8'd2);
    run_mask[0] = 1'b1;

    // R9 start-up timer expiry with current group not ready
    wr(2'd1, 1'b0, 1'b1);
    wr(2'd1, 1'b1, 1'b0);
    settle(1);
    check("R9 on secondary", {6'd0, cur_src}, 8'd1);
    src_ok[1] = 1'b0;
    exp_q.push_back(2'd2);
    settle(2);
    start_tmr_done = 1'b1;
    settle(1);
    check("R9 cur", {6'd0, cur_src}, 8'd2);
    check("R9 flag", {7'd0, clk_fail}, 8'd1);
    src_ok[1] = 1'b1;
    start_tmr_done = 1'b0;

    // R12 switching only
    cfg_mode = 2'b01;
    wr(2'd0, 1'b1, 1'b0);
    settle(1);
    check("R12 switch", {6'd0, cur_src}, 8'd0);
    run_mask[0] = 1'b0;
    settle(3 * WIN);
    check("R12 no fail", {6'd0, cur_src}, 8'd0);
    run_mask[0] = 1'b1;

    // R3 all off
    cfg_mode = 2'b10; cfg_osc = 2'd3;
    settle(2);
    check("R3 follow", {6'd0, cur_src}, 8'd3);
    wr(2'd1, 1'b1, 1'b0);
    check("R3 no pend", {7'd0, sw_pend}, 8'd0);
    run_mask[3] = 1'b0;
    settle(3 * WIN);
    check("R3 no fail", {6'd0, cur_src}, 8'd3);
    cfg_osc = 2'd0;
    settle(1);
    check("R3 follow2", {6'd0, cur_src}, 8'd0);

    check("R8 all traps seen", 8'(exp_q.size()), 8'd0);
    done = 1'b1;
    summary();
  end
endmodule